// File: doc/BRIEF.md
# Multispeed Data-Strobe Serializer

This block is the transmit half of a data-strobe coded serial port. The link side delivers one parallel word per system period. The block shifts that word out on a single serial data line and sends a companion strobe line beside it. The word carries 2, 4 or 8 meaningful bits, and the packet speed decides how many. Every speed delivers one whole word per system period, so the serial bit rate is 2, 4 or 8 times the system rate.

The whole block runs on one fast clock at eight times the system rate. A one-cycle `sys_ce` pulse marks each system period. Within the period, a phase counter issues a bit enable on every fast cycle, every second fast cycle or every fourth fast cycle, according to the speed. The encoder registers the data bit and flips the strobe whenever the new bit repeats the previous one. As a result, exactly one of the two lines changes in each bit period.

The speed is taken only when a packet starts and holds for the rest of the packet. When `tx_valid` is low at a word boundary, no new word is taken. Once the previous word has finished, both lines stay at their last values.

Top module: `ds_multispeed_tx`

## Requirements
- R1: After synchronous reset, `ser_data` and `ser_strobe` are both 0.
- R2: Speed code 2'b00 is the low speed: 2 bits per word, one bit every 4 fast cycles. Code 2'b01 is the middle speed: 4 bits per word, one bit every 2 cycles. Code 2'b10 is the high speed: 8 bits per word, one bit every cycle. Code 2'b11 behaves as the low speed.
- R3: The low speed sends `par_data[1:0]`, the middle speed sends `par_data[3:0]` and the high speed sends `par_data[7:0]`. In each case the most significant bit goes first, and bits above the selected width have no effect.
- R4: A word is captured on the fast edge where `sys_ce` and `tx_valid` are both high. Its first bit appears on the next edge, and each later bit follows one bit period after the one before.
- R5: On each bit period, `ser_data` takes the bit value. `ser_strobe` toggles exactly when that bit equals the previous `ser_data`, so exactly one line changes.
- R6: A packet starts on a `sys_ce` edge with `tx_valid` high when the previous `sys_ce` edge had `tx_valid` low, or when no word has been taken since reset. The speed is sampled only at that point. A change of `speed` inside a packet has no effect.
- R7: A `sys_ce` edge with `tx_valid` low takes no word. Once the bits of the previous word have been sent, both lines hold their values.
- R8: Each captured word yields exactly its lane count of bit periods before the next `sys_ce`, provided `sys_ce` pulses once every `WORD_W` fast cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock, `WORD_W` times the system rate |
| rst | input | 1 | Synchronous active-high reset |
| sys_ce | input | 1 | One-cycle pulse marking each system period |
| tx_valid | input | 1 | The word on `par_data` is to be sent |
| speed | input | 2 | Speed code, sampled at packet start |
| par_data | input | WORD_W | Parallel word from the link side |
| ser_data | output | 1 | Serial data line |
| ser_strobe | output | 1 | Serial strobe line |

## Verification
The assertions take for granted that `sys_ce` is a single-cycle pulse that repeats exactly every `WORD_W` fast cycles. The per-word bit count, and the assumption that the last high-speed bit lands on the next boundary edge, both rest on that spacing. The bench drives `sys_ce` from one task that always waits exactly eight fast cycles between pulses, idle words included. `tx_valid` and `speed` change only in the half-cycle before a pulse. Between packets the stimulus inserts at least one idle word, so every packet start is well defined.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

    typedef enum logic [1:0] {
        SPD_LOW  = 2'b00,
        SPD_MID  = 2'b01,
        SPD_HIGH = 2'b10,
        SPD_RSV  = 2'b11
    } ds_speed_e;

    typedef struct packed {
        logic data;
        logic strobe;
    } ds_line_t;

    // log2 of the number of fast cycles per serial bit
    function automatic int unsigned rate_shift(ds_speed_e s);
        case (s)
            SPD_MID:  return 1;
            SPD_HIGH: return 0;
            default:  return 2;
        endcase
    endfunction

    // bits carried per word at a given speed
    function automatic int unsigned lane_count(int unsigned word_w, ds_speed_e s);
        return word_w >> rate_shift(s);
    endfunction

endpackage

// File: rtl/ds_rate_ctrl.sv
module ds_rate_ctrl
    import ds_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sys_ce,
    input  logic       tx_valid,
    input  logic [1:0] speed_in,
    output ds_speed_e  load_spd,
    output logic       load,
    output logic       bit_ce
);
    localparam int PH_W = $clog2(WORD_W);

    ds_speed_e         spd_q;
    logic              active_q;
    logic [PH_W-1:0]   phase_q;
    logic [PH_W-1:0]   step_mask;
    logic              start;

    always_comb begin
        start     = sys_ce & tx_valid & ~active_q;
        load      = sys_ce & tx_valid;
        load_spd  = start ? ds_speed_e'(speed_in) : spd_q;
        step_mask = PH_W'((32'd1 << rate_shift(spd_q)) - 32'd1);
        bit_ce    = active_q && ((phase_q & step_mask) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spd_q    <= SPD_LOW;
            active_q <= 1'b0;
            phase_q  <= '0;
        end else if (sys_ce) begin
            active_q <= tx_valid;
            phase_q  <= '0;
            if (start) begin
                spd_q <= ds_speed_e'(speed_in);
            end
        end else if (active_q) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // bit periods issued for the word in flight
    logic [PH_W:0] n_emit_q;
    always_ff @(posedge clk) begin
        if (rst || sys_ce) begin
            n_emit_q <= '0;
        end else if (bit_ce) begin
            n_emit_q <= n_emit_q + 1'b1;
        end
    end

    // R8
    lane_count_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_ce && active_q) |->
            ((int'(n_emit_q) + int'(bit_ce)) == int'(lane_count(WORD_W, spd_q))));

endmodule

// File: rtl/ds_word_shifter.sv
module ds_word_shifter
    import ds_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              bit_ce,
    input  ds_speed_e         load_spd,
    input  logic [WORD_W-1:0] par_data,
    output logic              cur_bit
);
    logic [WORD_W-1:0] sreg_q;
    int unsigned       align;

    always_comb begin
        align   = WORD_W - lane_count(WORD_W, load_spd);
        cur_bit = sreg_q[WORD_W-1];
    end

    // a load and the last bit of the previous word may share an edge:
    // the encoder reads the old MSB while the new word replaces it
    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= par_data << align;
        end else if (bit_ce) begin
            sreg_q <= sreg_q << 1;
        end
    end

endmodule

// File: rtl/ds_strobe_enc.sv
module ds_strobe_enc
    import ds_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_ce,
    input  logic     bit_in,
    output ds_line_t line
);
    ds_line_t line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (bit_ce) begin
            line_q.data   <= bit_in;
            line_q.strobe <= line_q.strobe ^ (bit_in == line_q.data);
        end
    end

    assign line = line_q;

    // R5
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        bit_ce |=> ((line_q.data != $past(line_q.data)) ^
                    (line_q.strobe != $past(line_q.strobe))));

    // R7
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_ce |=> $stable(line_q));

endmodule

// File: rtl/ds_multispeed_tx.sv
module ds_multispeed_tx
    import ds_tx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_ce,
    input  logic              tx_valid,
    input  logic [1:0]        speed,
    input  logic [WORD_W-1:0] par_data,
    output logic              ser_data,
    output logic              ser_strobe
);
    ds_speed_e load_spd;
    logic      load;
    logic      bit_ce;
    logic      cur_bit;
    ds_line_t  line;

    ds_rate_ctrl #(.WORD_W(WORD_W)) u_rate (
        .clk      (clk),
        .rst      (rst),
        .sys_ce   (sys_ce),
        .tx_valid (tx_valid),
        .speed_in (speed),
        .load_spd (load_spd),
        .load     (load),
        .bit_ce   (bit_ce)
    );

    ds_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .bit_ce   (bit_ce),
        .load_spd (load_spd),
        .par_data (par_data),
        .cur_bit  (cur_bit)
    );

    ds_strobe_enc u_enc (
        .clk    (clk),
        .rst    (rst),
        .bit_ce (bit_ce),
        .bit_in (cur_bit),
        .line   (line)
    );

    assign ser_data   = line.data;
    assign ser_strobe = line.strobe;

    // R8
    ce_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sys_ce |=> !sys_ce);

endmodule

// File: tb/tb_ds_multispeed_tx.sv
module tb_ds_multispeed_tx;
    localparam int WORD_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sys_ce = 1'b0;
    logic              tx_valid = 1'b0;
    logic [1:0]        speed = 2'b00;
    logic [WORD_W-1:0] par_data = '0;
    logic              ser_data;
    logic              ser_strobe;

    ds_multispeed_tx #(.WORD_W(WORD_W)) dut (
        .clk(clk), .rst(rst), .sys_ce(sys_ce), .tx_valid(tx_valid),
        .speed(speed), .par_data(par_data),
        .ser_data(ser_data), .ser_strobe(ser_strobe)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic  d;
        logic  s;
        int    edge_at;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    int   edge_no = 0;
    logic mon_on = 1'b0;
    logic [1:0] last_seen;

    // bench model state
    logic       m_d = 1'b0;
    logic       m_s = 1'b0;
    logic       m_active = 1'b0;
    logic [1:0] m_spd = 2'b00;

    always @(posedge clk) edge_no <= edge_no + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // driver: one system period, pushing the bits it expects
    task automatic send_word(input logic valid, input logic [1:0] spd,
                             input logic [7:0] data, input string req);
        int le, lanes, step;
        @(negedge clk);
        sys_ce   = 1'b1;
        tx_valid = valid;
        speed    = spd;
        par_data = data;
        le = edge_no + 1;
        if (valid) begin
            if (!m_active) m_spd = spd;
            case (m_spd)
                2'b01:   begin lanes = 4; step = 2; end
                2'b10:   begin lanes = 8; step = 1; end
                default: begin lanes = 2; step = 4; end
            endcase
            for (int i = 0; i < lanes; i++) begin
                logic b;
                exp_t e;
                b   = data[lanes-1-i];
                m_s = m_s ^ (b == m_d);
                m_d = b;
                e.d = m_d; e.s = m_s; e.edge_at = le + 1 + i*step; e.req = req;
                exp_q.push_back(e);
            end
        end
        m_active = valid;
        @(negedge clk);
        sys_ce = 1'b0;
        repeat (WORD_W-2) @(negedge clk);
    endtask

    // monitor: every line change is one bit period
    always @(negedge clk) begin
        if (mon_on && ({ser_data, ser_strobe} != last_seen)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected line change", int'({ser_data, ser_strobe}), int'(last_seen));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({ser_data, ser_strobe} == {e.d, e.s}, e.req, "line value {data,strobe}",
                      int'({ser_data, ser_strobe}), int'({e.d, e.s}));
                check(edge_no == e.edge_at, "R4", "bit edge", edge_no, e.edge_at);
            end
            last_seen = {ser_data, ser_strobe};
        end
    end

    initial begin
        #(200000 * 10);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check({ser_data, ser_strobe} == 2'b00, "R1", "reset lines", int'({ser_data, ser_strobe}), 0);
        last_seen = 2'b00;
        mon_on = 1'b1;

        send_word(1'b0, 2'b00, 8'h00, "R7");
        send_word(1'b0, 2'b00, 8'h00, "R7");

        // R2 R3 R5: high speed packet, incl. run of repeats
        send_word(1'b1, 2'b10, 8'hA5, "R2");
        send_word(1'b1, 2'b10, 8'h3C, "R3");
        send_word(1'b1, 2'b10, 8'hFF, "R5");
        send_word(1'b0, 2'b10, 8'h00, "R7");

        // R6: middle speed; speed input moves mid-packet, upper bits set
        send_word(1'b1, 2'b01, 8'hF9, "R3");
        send_word(1'b1, 2'b10, 8'hA6, "R6");
        send_word(1'b1, 2'b00, 8'h50, "R6");
        send_word(1'b0, 2'b00, 8'h00, "R7");

        // R2 R3: low speed, upper bits ignored
        send_word(1'b1, 2'b00, 8'hFE, "R3");
        send_word(1'b1, 2'b00, 8'h01, "R2");
        send_word(1'b1, 2'b00, 8'h03, "R5");
        send_word(1'b0, 2'b01, 8'hFF, "R7");

        // R2: reserved code runs at low speed
        send_word(1'b1, 2'b11, 8'hFE, "R2");
        send_word(1'b1, 2'b11, 8'h00, "R2");
        send_word(1'b0, 2'b00, 8'h00, "R7");

        // R7: idle words leave the lines alone
        begin
            logic [1:0] held;
            held = {ser_data, ser_strobe};
            send_word(1'b0, 2'b10, 8'hFF, "R7");
            send_word(1'b0, 2'b10, 8'hAA, "R7");
            check({ser_data, ser_strobe} == held, "R7", "held lines", int'({ser_data, ser_strobe}), int'(held));
        end
        // R8: every expected bit period arrived
        check(exp_q.size() == 0, "R8", "pending bits", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule